// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Generator

This block drives one leg of a half-bridge or full-bridge. It produces a high-side and a low-side gate signal from a single triangle timebase. The timebase counts up from zero to a programmed period and then back down to zero. Each output has its own compare level. The high-side output is on while the count is below its level. The low-side output is on while the count is above its level. Because the counter runs in both directions, both edges of each pulse move when a level changes. The pulses stay centred on the count turning points.

There is no dead-time counter. The dead time comes entirely from the gap between the two compare levels. Software writes the period and both levels through a small write port into staging registers. The staged values become active together when the count re-enters zero. A change made mid-cycle therefore never skips or splits an edge. A count of zero marks the start of each cycle, and a one-clock event output flags it for use as an interrupt.

An external fault input passes through a two-stage synchronizer. While it is active, it blanks both outputs for the remainder of the running cycle. A sticky fault flag records that a fault happened until software clears it.

Top module: `cpwm_bridge`

## Requirements
- R1: After reset both gate outputs, the cycle event and the fault flag are low, and all staged and active settings are zero.
- R2: With a nonzero active period P the count runs 0,1,…,P,P-1,…,1 and repeats. This gives a cycle of 2P clocks. cycle_evt is high for exactly the one clock in which the count is zero.
- R3: gate_hi is high while the count is below the high-side level L (1 ≤ L ≤ P), which gives 2L-1 high clocks per cycle.
- R4: gate_lo is high while the count is above the low-side level H (H < P), which gives 2(P-H)-1 high clocks per cycle.
- R5: When H ≥ L the two outputs are never high together. Both are low for 2(H-L)+2 clocks per cycle.
- R6: Written settings become active together only on the clock at which the count enters zero. A write in mid-cycle leaves the running cycle unchanged.
- R7: An active period of zero holds the count at zero, keeps both outputs low and raises no cycle event. In that state, staged settings load on every clock.
- R8: fault_in passes through two flip-flops. From the second clock edge after it rises, both outputs are low until the next cycle start. Outputs resume at that start if the synchronized fault has dropped, and stay low while it remains high.
- R9: fault_flag sets whenever the synchronized fault is high. It clears on a write to the clear address. If a set and a clear happen on the same clock, the set wins.
- R10: Write address map on wr_sel: 0 = period, 1 = high-side level, 2 = low-side level, 3 = clear fault flag (the data is ignored).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one clock per write |
| wr_sel | input | 2 | Write target (see R10) |
| wr_data | input | 16 | Write value |
| fault_in | input | 1 | Asynchronous fault/trip input, active high |
| gate_hi | output | 1 | High-side gate drive |
| gate_lo | output | 1 | Low-side gate drive |
| cycle_evt | output | 1 | One-clock pulse at count zero |
| fault_flag | output | 1 | Sticky fault record |

## Verification
The assertion that the outputs never overlap only applies while the active low-side level is at least the high-side level. The property is guarded on that relation, and the directed patterns always write levels with H ≥ L. The fault-blanking checks assume that fault_in is held for at least two clocks so that the synchronizer sees it. The bench drives two-clock and longer pulses. The checks that count clocks per cycle rely on L ≥ 1 and H < P, so the stimulus keeps every pattern inside those bounds.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

    localparam int CW = 16;

    typedef logic [CW-1:0] cval_t;

    typedef enum logic [1:0] {
        SEL_PERIOD    = 2'd0,
        SEL_LVL_HI    = 2'd1,
        SEL_LVL_LO    = 2'd2,
        SEL_FAULT_CLR = 2'd3
    } wr_sel_e;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } cnt_dir_e;

    typedef struct packed {
        cval_t period;
        cval_t lvl_hi;
        cval_t lvl_lo;
    } pwm_cfg_t;

    function automatic logic is_idle(input pwm_cfg_t cfg);
        return cfg.period == '0;
    endfunction

endpackage

// File: rtl/cpwm_regs.sv
module cpwm_regs
    import cpwm_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  cval_t        wr_data,
    input  logic         cycle_load,
    output pwm_cfg_t     act_cfg,
    output logic         fault_clr
);

    pwm_cfg_t stage_cfg;
    wr_sel_e  sel;

    assign sel       = wr_sel_e'(wr_sel);
    assign fault_clr = wr_en && (sel == SEL_FAULT_CLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_cfg <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_PERIOD: stage_cfg.period <= wr_data;
                SEL_LVL_HI: stage_cfg.lvl_hi <= wr_data;
                SEL_LVL_LO: stage_cfg.lvl_lo <= wr_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_cfg <= '0;
        else if (cycle_load)
            act_cfg <= stage_cfg;
    end

    // R6: active settings only move at a cycle boundary
    a_r6_hold_mid_cycle: assert property (@(posedge clk) disable iff (rst)
        !cycle_load |=> $stable(act_cfg));

endmodule

// File: rtl/cpwm_timebase.sv
module cpwm_timebase
    import cpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cval_t  period,
    output cval_t  cnt,
    output logic   cycle_load
);

    cval_t    cnt_q, cnt_d;
    cnt_dir_e dir_q, dir_d;

    always_comb begin
        cnt_d = cnt_q;
        dir_d = dir_q;
        if (period == '0) begin
            cnt_d = '0;
        end else if (dir_q == DIR_RISE) begin
            if (cnt_q >= period) begin
                cnt_d = cnt_q - cval_t'(1);
                dir_d = DIR_FALL;
            end else begin
                cnt_d = cnt_q + cval_t'(1);
            end
        end else begin
            cnt_d = cnt_q - cval_t'(1);
        end
        if (cnt_d == '0)
            dir_d = DIR_RISE;
    end

    assign cycle_load = (period == '0) || (cnt_d == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            dir_q <= DIR_RISE;
        end else begin
            cnt_q <= cnt_d;
            dir_q <= dir_d;
        end
    end

    assign cnt = cnt_q;

    // R2: count never leaves the range 0..period
    a_r2_cnt_within_period: assert property (@(posedge clk) disable iff (rst)
        (period != '0) |-> (cnt_q <= period));

    // R7: idle period pins the count at zero
    a_r7_idle_holds_zero: assert property (@(posedge clk) disable iff (rst)
        (period == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/cpwm_fault.sv
module cpwm_fault #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic fault_in,
    input  logic cycle_load,
    input  logic flag_clr,
    output logic fault_live,
    output logic blank,
    output logic fault_flag
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] sync_q;
    logic          hold_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= fault_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[LAST-1:0], fault_in};
            end
        end
    endgenerate

    assign fault_live = sync_q[LAST];

    always_ff @(posedge clk) begin
        if (rst)             hold_q <= 1'b0;
        else if (cycle_load) hold_q <= 1'b0;
        else if (fault_live) hold_q <= 1'b1;
    end

    assign blank = fault_live || hold_q;

    always_ff @(posedge clk) begin
        if (rst)             fault_flag <= 1'b0;
        else if (fault_live) fault_flag <= 1'b1;
        else if (flag_clr)   fault_flag <= 1'b0;
    end

    // R8: blanking persists until the cycle boundary
    a_r8_blank_to_boundary: assert property (@(posedge clk) disable iff (rst)
        (blank && !cycle_load) |=> blank);

    // R9: a seen fault always leaves the flag set
    a_r9_flag_sets: assert property (@(posedge clk) disable iff (rst)
        fault_live |=> fault_flag);

endmodule

// File: rtl/cpwm_bridge.sv
module cpwm_bridge
    import cpwm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [1:0]  wr_sel,
    input  logic [15:0] wr_data,
    input  logic        fault_in,
    output logic        gate_hi,
    output logic        gate_lo,
    output logic        cycle_evt,
    output logic        fault_flag
);

    pwm_cfg_t cfg;
    cval_t    cnt;
    logic     cycle_load;
    logic     fault_clr;
    logic     fault_live;
    logic     blank;
    logic     run;

    cpwm_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .cycle_load (cycle_load),
        .act_cfg    (cfg),
        .fault_clr  (fault_clr)
    );

    cpwm_timebase u_tb (
        .clk        (clk),
        .rst        (rst),
        .period     (cfg.period),
        .cnt        (cnt),
        .cycle_load (cycle_load)
    );

    cpwm_fault #(.STAGES(SYNC_STAGES)) u_fault (
        .clk        (clk),
        .rst        (rst),
        .fault_in   (fault_in),
        .cycle_load (cycle_load),
        .flag_clr   (fault_clr),
        .fault_live (fault_live),
        .blank      (blank),
        .fault_flag (fault_flag)
    );

    assign run       = !is_idle(cfg);
    assign gate_hi   = run && !blank && (cnt < cfg.lvl_hi);
    assign gate_lo   = run && !blank && (cnt > cfg.lvl_lo);
    assign cycle_evt = run && (cnt == '0);

    // R5: ordered levels never let both switches conduct
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (cfg.lvl_lo >= cfg.lvl_hi) |-> !(gate_hi && gate_lo));

    // R8: a synchronized fault forces both outputs off
    a_r8_fault_blanks: assert property (@(posedge clk) disable iff (rst)
        fault_live |-> (!gate_hi && !gate_lo));

    // R2: cycle event is a single-clock pulse
    a_r2_evt_single: assert property (@(posedge clk) disable iff (rst)
        cycle_evt |=> !cycle_evt);

endmodule

// File: tb/test_cpwm_bridge.sv
module test_cpwm_bridge;
    import cpwm_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        fault_in;
    logic        gate_hi, gate_lo, cycle_evt, fault_flag;

    int n_checks = 0;
    int n_fails  = 0;

    always #4 clk = ~clk;

    cpwm_bridge i_cpwm_bridge (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .fault_in   (fault_in),
        .gate_hi    (gate_hi),
        .gate_lo    (gate_lo),
        .cycle_evt  (cycle_evt),
        .fault_flag (fault_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] sel, input int val);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = val[15:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_evt();
        int guard = 0;
        while (!cycle_evt && guard < 1000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic configure(input int p, input int lh, input int ll);
        write_reg(SEL_LVL_LO, ll);
        write_reg(SEL_LVL_HI, lh);
        write_reg(SEL_PERIOD, p);
        wait_evt();
        @(negedge clk);
        wait_evt();
    endtask

    task automatic t_reset();
        rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; fault_in = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 gate_hi", int'(gate_hi), 0);
        check("R1 gate_lo", int'(gate_lo), 0);
        check("R1 cycle_evt", int'(cycle_evt), 0);
        check("R1 fault_flag", int'(fault_flag), 0);
    endtask

    task automatic t_idle_period();
        int nh = 0, nl = 0, ne = 0;
        write_reg(SEL_LVL_HI, 5);
        write_reg(SEL_LVL_LO, 7);
        for (int i = 0; i < 20; i++) begin
            nh += int'(gate_hi); nl += int'(gate_lo); ne += int'(cycle_evt);
            @(negedge clk);
        end
        check("R7 idle gate_hi", nh, 0);
        check("R7 idle gate_lo", nl, 0);
        check("R7 idle no event", ne, 0);
    endtask

    // R2 R3 R4 R5: one full cycle measured from the event
    task automatic t_pattern(input int p, input int lh, input int ll);
        int nh = 0, nl = 0, nlow = 0, ne = 0;
        configure(p, lh, ll);
        for (int i = 0; i < 2 * p; i++) begin
            nh   += int'(gate_hi);
            nl   += int'(gate_lo);
            nlow += int'(!gate_hi && !gate_lo);
            ne   += int'(cycle_evt);
            @(negedge clk);
        end
        check("R2 one event per cycle", ne, 1);
        check("R2 event after 2P clocks", int'(cycle_evt), 1);
        check("R3 high-side clocks", nh, 2 * lh - 1);
        check("R4 low-side clocks", nl, 2 * (p - ll) - 1);
        check("R5 deadband clocks", nlow, 2 * (ll - lh) + 2);
    endtask

    task automatic t_shadow();
        int n_old = 0, n_new = 0;
        configure(10, 4, 6);
        for (int i = 0; i < 20; i++) begin
            n_old += int'(gate_hi);
            if (i == 3) begin
                wr_en = 1'b1; wr_sel = SEL_LVL_HI; wr_data = 16'd2;
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
        for (int i = 0; i < 20; i++) begin
            n_new += int'(gate_hi);
            @(negedge clk);
        end
        check("R6 mid-cycle write deferred", n_old, 7);
        check("R6 write active next cycle", n_new, 3);
    endtask

    task automatic t_fault_pulse();
        int lo_at8 = 0, on_blank = 0, hi_at20 = 0, evt20 = 0;
        configure(10, 4, 6);
        for (int i = 0; i <= 20; i++) begin
            if (i == 8)  lo_at8 = int'(gate_lo);
            if (i >= 9 && i <= 19) on_blank += int'(gate_hi) + int'(gate_lo);
            if (i == 20) begin hi_at20 = int'(gate_hi); evt20 = int'(cycle_evt); end
            if (i == 7) fault_in = 1'b1;
            if (i == 9) fault_in = 1'b0;
            @(negedge clk);
        end
        check("R8 output live before sync delay", lo_at8, 1);
        check("R8 blanked to cycle end", on_blank, 0);
        check("R8 cycle boundary seen", evt20, 1);
        check("R8 resume next cycle", hi_at20, 1);
        check("R9 flag set by fault", int'(fault_flag), 1);
    endtask

    task automatic t_flag_clear();
        fault_in = 1'b1;
        repeat (3) @(negedge clk);
        write_reg(SEL_FAULT_CLR, 16'hFFFF);
        check("R9 set wins over clear", int'(fault_flag), 1);
        wait_evt();
        check("R8 held fault keeps gate_hi low", int'(gate_hi), 0);
        fault_in = 1'b0;
        repeat (4) @(negedge clk);
        write_reg(SEL_FAULT_CLR, 0);
        check("R9 R10 clear via address 3", int'(fault_flag), 0);
        wait_evt();
        check("R8 outputs back after release", int'(gate_hi), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_period();
        t_pattern(10, 4, 6);
        t_pattern(7, 1, 1);
        t_pattern(20, 5, 12);
        t_shadow();
        t_fault_pulse();
        t_flag_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule